// File: doc/BRIEF.md
# Baseband Power Mode Controller

This block turns three control levels, a receive enable, a transmit enable and a sleep request, into a registered operating mode for a transceiver baseband. It drives enable outputs for the receive and transmit datapaths. It also raises a ready flag for each path once that path's wake-up time has passed. The modes are sleep, standby, receive-only, transmit-only and full operation. The sleep request sends the receiver to sleep. With the receive enable also low, it gives the lowest-power state, in which both paths are off.

Wake-up times are counted in ticks of a master-clock divider, so one tick can stand for one microsecond. The receiver needs a long wake-up time after a sleep and a short one otherwise. The transmitter is ready after a fixed, small number of raw clock edges. A small retained register array holds configuration words and learned gain and noise-floor values. It stays writable and readable in every mode, and nothing in the block ever clears it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `rx_on_o` equals `rx_en_i && !sleep_req_i` as sampled at the previous rising edge.
- R2: `tx_on_o` equals `tx_en_i` as sampled at the previous rising edge, except that it is 0 when `sleep_req_i` was high and `rx_en_i` was low.
- R3: `mode_o` is registered and takes these values: 0 = sleep (sleep request high and transmit path off), 1 = standby (no request, both enables low), 2 = receive only, 3 = transmit only, 4 = both paths on.
- R4: If the sleep request has been seen high (or the block reset) since the receiver was last ready, `rx_ready_o` rises after the `SLEEP_TICKS*CLK_DIV`-th consecutive rising edge at which the receive path is enabled.
- R5: In every other case, `rx_ready_o` rises after the `RX_TICKS*CLK_DIV`-th such edge.
- R6: `tx_ready_o` rises after the `TX_CYC`-th consecutive rising edge at which the transmit path is enabled.
- R7: A ready flag is 0 from the first edge at which its path is seen disabled. A countdown that is cut short is discarded, and the next enable starts it again from zero.
- R8: A write with `cfg_we_i` high stores `cfg_wdata_i` at `cfg_addr_i` in any mode. `cfg_rdata_o` shows the word at the address sampled at the previous edge. Stored words are never changed by the sleep request, the mode or `rst`.
- R9: While `rst` is high, all enable and ready outputs are 0 and `mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset of the mode logic |
| rx_en_i | input | 1 | Receive power enable |
| tx_en_i | input | 1 | Transmit power enable |
| sleep_req_i | input | 1 | Sleep request (puts the receiver to sleep) |
| rx_on_o | output | 1 | Receive datapath enable |
| tx_on_o | output | 1 | Transmit datapath enable |
| rx_ready_o | output | 1 | Receiver wake-up complete |
| tx_ready_o | output | 1 | Transmitter wake-up complete |
| mode_o | output | 3 | Operating mode code |
| cfg_we_i | input | 1 | Retained storage write strobe |
| cfg_addr_i | input | ADDR_W | Retained storage address |
| cfg_wdata_i | input | DATA_W | Retained storage write data |
| cfg_rdata_o | output | DATA_W | Retained storage read data |

## Verification
The assertions assume that the control inputs are synchronous levels that settle well before each rising edge. They also assume that `rst` is high from time zero for at least one edge. The bench changes every input only on falling clock edges and begins with several edges of reset. Latencies are measured by counting rising edges from the falling edge on which an enable is raised, and the inputs are held steady during each count. The bench uses a divider of 4 so that the long sleep exit stays short.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_SLEEP   = 3'd0,
    PM_STANDBY = 3'd1,
    PM_RX      = 3'd2,
    PM_TX      = 3'd3,
    PM_FULL    = 3'd4
  } pm_mode_e;
endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rx_en,
  input  logic     tx_en,
  input  logic     sleep_req,
  output logic     rx_on_nxt,
  output logic     tx_on_nxt,
  output logic     rx_on_q,
  output logic     tx_on_q,
  output pm_mode_e mode_q
);
  pm_mode_e mode_nxt;

  always_comb begin
    rx_on_nxt = rx_en && !sleep_req;
    tx_on_nxt = tx_en && !(sleep_req && !rx_en);
    if (sleep_req && !tx_on_nxt)      mode_nxt = PM_SLEEP;
    else if (rx_on_nxt && tx_on_nxt)  mode_nxt = PM_FULL;
    else if (rx_on_nxt)               mode_nxt = PM_RX;
    else if (tx_on_nxt)               mode_nxt = PM_TX;
    else                              mode_nxt = PM_STANDBY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_on_q <= 1'b0;
      tx_on_q <= 1'b0;
      mode_q  <= PM_SLEEP;
    end else begin
      rx_on_q <= rx_on_nxt;
      tx_on_q <= tx_on_nxt;
      mode_q  <= mode_nxt;
    end
  end

  // R1
  sleep_blocks_rx_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> !rx_on_q);

  // R2
  deep_sleep_blocks_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !rx_en) |=> (!tx_on_q && mode_q == PM_SLEEP));
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int DIV    = 44,
  parameter int THR_LO = 1,
  parameter int THR_HI = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_hi,
  output logic rdy
);
  localparam int THR_MAX = (THR_HI > THR_LO) ? THR_HI : THR_LO;
  localparam int PRE_W   = $clog2(DIV + 1);
  localparam int CNT_W   = $clog2(THR_MAX + 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = sel_hi ? CNT_W'(THR_HI - 1) : CNT_W'(THR_LO - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre <= '0;
      cnt <= '0;
      rdy <= 1'b0;
    end else if (!rdy) begin
      if (pre == PRE_W'(DIV - 1)) begin
        pre <= '0;
        if (cnt == last) rdy <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  // R7
  rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rdy);

  // R7
  rdy_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> $past(en));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(THR_MAX - 1) && pre <= PRE_W'(DIV - 1));
endmodule

// File: rtl/pwr_retain_regs.sv
module pwr_retain_regs #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CLK_DIV     = 44,
  parameter int SLEEP_TICKS = 10,
  parameter int RX_TICKS    = 1,
  parameter int TX_CYC      = 2,
  parameter int CFG_DEPTH   = 16,
  parameter int DATA_W      = 16,
  localparam int ADDR_W     = $clog2(CFG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic              sleep_req_i,
  output logic              rx_on_o,
  output logic              tx_on_o,
  output logic              rx_ready_o,
  output logic              tx_ready_o,
  output logic [2:0]        mode_o,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o
);
  logic     rx_on_nxt, tx_on_nxt;
  pm_mode_e mode_q;
  logic     deep_q;

  pwr_mode_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en_i),
    .tx_en     (tx_en_i),
    .sleep_req (sleep_req_i),
    .rx_on_nxt (rx_on_nxt),
    .tx_on_nxt (tx_on_nxt),
    .rx_on_q   (rx_on_o),
    .tx_on_q   (tx_on_o),
    .mode_q    (mode_q)
  );
  assign mode_o = mode_q;

  always_ff @(posedge clk) begin
    if (rst || sleep_req_i) deep_q <= 1'b1;
    else if (rx_ready_o)    deep_q <= 1'b0;
  end

  pwr_wake_timer #(.DIV(CLK_DIV), .THR_LO(RX_TICKS), .THR_HI(SLEEP_TICKS)) u_rx_wake (
    .clk    (clk),
    .rst    (rst),
    .en     (rx_on_nxt),
    .sel_hi (deep_q),
    .rdy    (rx_ready_o)
  );

  pwr_wake_timer #(.DIV(1), .THR_LO(TX_CYC), .THR_HI(TX_CYC)) u_tx_wake (
    .clk    (clk),
    .rst    (rst),
    .en     (tx_on_nxt),
    .sel_hi (1'b0),
    .rdy    (tx_ready_o)
  );

  pwr_retain_regs #(.DEPTH(CFG_DEPTH), .DATA_W(DATA_W)) u_retain (
    .clk   (clk),
    .we    (cfg_we_i),
    .addr  (cfg_addr_i),
    .wdata (cfg_wdata_i),
    .rdata (cfg_rdata_o)
  );

  // R7
  rx_ready_gated_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready_o |-> rx_on_o);

  // R7
  tx_ready_gated_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |-> tx_on_o);

  // R3
  sleep_paths_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0) |-> (!rx_on_o && !tx_on_o));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rx_ready_o && !tx_ready_o && mode_o == 3'd0));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int SLP   = 10;
  localparam int RXT   = 1;
  localparam int TXC   = 2;
  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 0, tx_en = 0, slp = 0;
  logic rx_on, tx_on, rx_rdy, tx_rdy;
  logic [2:0] mode;
  logic we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_mode_ctrl #(.CLK_DIV(DIV), .SLEEP_TICKS(SLP), .RX_TICKS(RXT), .TX_CYC(TXC),
                  .CFG_DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .rx_en_i(rx_en), .tx_en_i(tx_en), .sleep_req_i(slp),
    .rx_on_o(rx_on), .tx_on_o(tx_on), .rx_ready_o(rx_rdy), .tx_ready_o(tx_rdy),
    .mode_o(mode), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic t);
    @(negedge clk);
    slp = s; rx_en = r; tx_en = t;
  endtask

  task automatic measure(input bit is_tx, output int n);
    n = -1;
    for (int i = 1; i <= 1000; i++) begin
      @(posedge clk); #1;
      if (is_tx ? tx_rdy : rx_rdy) begin n = i; break; end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int exp_mode;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 rx_on", rx_on, 0);  check("R9 tx_on", tx_on, 0);
    check("R9 rx_rdy", rx_rdy, 0); check("R9 tx_rdy", tx_rdy, 0);
    check("R9 mode", mode, 0);
    @(negedge clk); rst = 0;

    // R1 R2 R3 sweep of all input combinations
    for (int c = 0; c < 8; c++) begin
      logic s, r, t, eon_r, eon_t;
      s = c[2]; r = c[1]; t = c[0];
      drive(s, r, t);
      @(posedge clk); #1;
      eon_r = r && !s;
      eon_t = t && !(s && !r);
      if (s && !eon_t) exp_mode = 0;
      else if (eon_r && eon_t) exp_mode = 4;
      else if (eon_r) exp_mode = 2;
      else if (eon_t) exp_mode = 3;
      else exp_mode = 1;
      check("R1 rx_on", rx_on, eon_r);
      check("R2 tx_on", tx_on, eon_t);
      check("R3 mode", mode, exp_mode);
    end

    // R4 first wake after reset uses the long count; R7 cancel first
    drive(0, 0, 0);
    drive(0, 1, 0);
    repeat (20) @(posedge clk);
    #1; check("R7 mid-count not ready", rx_rdy, 0);
    drive(0, 0, 0);
    @(posedge clk); #1;
    check("R7 cancel rx_rdy", rx_rdy, 0);
    drive(0, 1, 0);
    measure(0, n);
    check("R4 sleep exit latency", n, SLP * DIV);
    // R7 immediate drop
    drive(0, 0, 0);
    @(posedge clk); #1;
    check("R7 drop rx_rdy", rx_rdy, 0);
    // R5 short wake from standby
    drive(0, 1, 0);
    measure(0, n);
    check("R5 standby rx latency", n, RXT * DIV);
    // R4 after a sleep pulse
    drive(1, 0, 0);
    drive(0, 0, 0);
    drive(0, 1, 0);
    measure(0, n);
    check("R4 latency after sleep", n, SLP * DIV);
    // R5 again, tx already on
    drive(0, 0, 1);
    drive(0, 1, 1);
    measure(0, n);
    check("R5 rx latency with tx on", n, RXT * DIV);

    // R6 tx latency from standby and from sleep
    drive(0, 0, 0);
    drive(0, 0, 1);
    measure(1, n);
    check("R6 tx latency standby", n, TXC);
    drive(1, 0, 0);
    @(posedge clk); #1;
    check("R7 tx_rdy drop in sleep", tx_rdy, 0);
    drive(0, 0, 1);
    measure(1, n);
    check("R6 tx latency after sleep", n, TXC);
    drive(0, 0, 1);
    @(posedge clk); #1;
    check("R6 tx_rdy held", tx_rdy, 1);

    // R8 retained storage: write in sleep, disturb, read back
    drive(1, 0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      we = 1; addr = AW'(a); wdata = DW'(a * 37 + 5);
    end
    @(negedge clk); we = 0;
    drive(0, 1, 1);
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0; slp = 1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); addr = AW'(a);
      @(posedge clk); #1;
      check("R8 retained word", rdata, DW'(a * 37 + 5));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule